// File: doc/BRIEF.md
# Programmable Serial Shift Slice

The block is one lane group of a general-purpose serial engine. A 32-bit working register moves data right by 1, 2, 4 or 8 bits on each shift event. New data from the serial input bus enters at the top and the low bits leave on the serial output bus. Shift events come from one of two sources. The first is a local 12-bit reloadable down counter, which divides the slice clock. The second is an external clock pin, which is synchronized and edge-detected. A qualifier pin can gate either source.

An 8-bit word counter counts shift events. At each word boundary the working register and a shadow register change places in a single cycle. The host fills or drains the shadow word through a flat register port while the next word is being shifted.

The serial buses carry no valid/ready handshake. The slice takes and presents serial data only on its own shift events, so there is no back-pressure. The peer must present data that is stable at those events and sample the output between them. The host port is a plain write strobe with a combinational read.

Top module: `serial_shift_slice`

## Requirements
- R1: `cfg_lane_mode` picks the lane width N: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. On a shift event that is not a word boundary, the working register becomes `{ser_in[N-1:0], reg[31:N]}`. The bits of `ser_in` above N have no effect.
- R2: `ser_out[N-1:0]` always shows `reg[N-1:0]`, and `ser_out` bits at N and above read 0.
- R3: In local mode (`cfg_ext_sel`=0), the counter steps down by one each cycle and reloads from the divider reload value after reaching zero. Each visit to zero is a shift event, so shift events repeat every reload+1 cycles.
- R4: A host write of V to the divider count (address 1) takes effect on the write edge and sets the phase. In local mode with no qualifier gating, the first event is visible in the V-th cycle after the write edge.
- R5: The word counter counts shift events down. A shift event that finds it at zero is a word boundary and reloads it from the word reload value. Boundaries therefore come every reload+1 events, and a reload of 0 makes every event a boundary. A host write of V to the word count (address 3) makes event V+1 the next boundary.
- R6: At a boundary the shadow register takes the freshly shifted word and the working register takes the old shadow word, both on the same edge. `swap_pulse` is high for exactly that cycle. Otherwise the shadow changes only by a host write.
- R7: In external mode (`cfg_ext_sel`=1), each rising edge of `ext_clk_in` passes through a two-flop synchronizer and makes a one-cycle event. That event is visible two edges after the pin rises. The local counter causes no events in this mode.
- R8: With `cfg_qual_en`=1 and `qual_in`=0, no shift, word count or swap takes place. With `qual_in`=1, or with `cfg_qual_en`=0, events pass.
- R9: Host addresses: 0 divider reload (12 bits), 1 divider count (12 bits), 2 word reload (8 bits), 3 word count (8 bits), 4 shadow (32 bits). Reads are zero-extended, and write bits above a field's width are dropped. Reset clears every register and holds `swap_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lane_mode | input | 2 | Lane width code (1/2/4/8 bits) |
| cfg_ext_sel | input | 1 | 1 selects the external clock pin as the shift source |
| cfg_qual_en | input | 1 | 1 makes `qual_in` gate shift events |
| ext_clk_in | input | 1 | Asynchronous external shift clock |
| qual_in | input | 1 | Shift qualifier |
| ser_in | input | 8 | Serial input lanes |
| ser_out | output | 8 | Serial output lanes |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 32 | Host read data (combinational) |
| swap_pulse | output | 1 | One-cycle strobe on a word-boundary exchange |

## Verification
The assertions assume that `cfg_lane_mode`, `cfg_ext_sel` and `cfg_qual_en` change only while the slice is idle or in a mode where the change cannot split an event. They also assume that the host does not write the shadow in a boundary cycle. The stimulus keeps within these limits. It changes configuration only at falling edges between events and writes registers while the external pin is low. Each external pulse is held high for three cycles and low for three more, so that every rising edge clears the synchronizer.

// File: rtl/shift_slice_pkg.sv
package shift_slice_pkg;

  // host register map (address decode is behaviour the bench relies on)
  localparam logic [2:0] ADDR_DIV_RELOAD  = 3'd0;
  localparam logic [2:0] ADDR_DIV_COUNT   = 3'd1;
  localparam logic [2:0] ADDR_WORD_RELOAD = 3'd2;
  localparam logic [2:0] ADDR_WORD_COUNT  = 3'd3;
  localparam logic [2:0] ADDR_SHADOW      = 3'd4;

  localparam int LANE_MAX  = 8;
  localparam int NUM_MODES = 4;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2,
    LANE_X8 = 2'd3
  } lane_mode_e;

endpackage

// File: rtl/tick_source.sv
module tick_source #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             qual_en,
  input  logic             ext_clk_in,
  input  logic             qual_in,
  input  logic             reload_wr,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] count_q,
  output logic             shift_evt
);

  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_edge;
  logic                 local_tick;
  logic                 raw_tick;

  // divider reload value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_wr) reload_q <= wr_val;
  end

  // free-running divider, host write sets the phase
  assign local_tick = (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_q <= '0;
    else if (count_wr)   count_q <= wr_val;
    else if (local_tick) count_q <= reload_q;
    else                 count_q <= count_q - CNT_W'(1);
  end

  // R3 divider reloads after its terminal value
  AST_DIV_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (local_tick && !count_wr) |=> (count_q == $past(reload_q))); // R3

  // external clock: synchronizer plus one extra stage for rising-edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_in};
  end

  assign ext_edge  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign raw_tick  = ext_sel ? ext_edge : local_tick;
  assign shift_evt = rst_n & raw_tick & (~qual_en | qual_in);

  // R7 external edges never give back-to-back events
  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && shift_evt) |=> !(ext_sel && shift_evt)); // R7

  // R8 a low qualifier blocks every event
  AST_QUAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_en && !qual_in) |-> !shift_evt); // R8

endmodule

// File: rtl/word_counter.sv
module word_counter #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_evt,
  input  logic             reload_wr,
  input  logic             count_wr,
  input  logic [POS_W-1:0] wr_val,
  output logic [POS_W-1:0] reload_q,
  output logic [POS_W-1:0] count_q,
  output logic             boundary
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_wr) reload_q <= wr_val;
  end

  assign boundary = shift_evt & (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (count_wr)  count_q <= wr_val;
    else if (boundary)  count_q <= reload_q;
    else if (shift_evt) count_q <= count_q - POS_W'(1);
  end

  // R5 after a boundary the counter restarts from the reload value
  AST_POS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !count_wr) |=> (count_q == $past(reload_q))); // R5

  // R5 without an event or write the counter holds
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && !count_wr) |=> $stable(count_q)); // R5

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import shift_slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lane_mode_e          lane_mode,
  input  logic                shift_evt,
  input  logic                swap,
  input  logic [LANE_MAX-1:0] ser_in,
  input  logic [DATA_W-1:0]   shadow_in,
  output logic [DATA_W-1:0]   shifted,
  output logic [LANE_MAX-1:0] ser_out
);

  logic [DATA_W-1:0]   data_q;
  logic [DATA_W-1:0]   cand [NUM_MODES];
  logic [LANE_MAX-1:0] outs [NUM_MODES];

  // one candidate per lane width
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_lane
    localparam int W = 1 << g;
    localparam logic [LANE_MAX-1:0] MASK = LANE_MAX'((1 << W) - 1);
    assign cand[g] = {ser_in[W-1:0], data_q[DATA_W-1:W]};
    assign outs[g] = data_q[LANE_MAX-1:0] & MASK;
  end

  assign shifted = cand[lane_mode];
  assign ser_out = outs[lane_mode];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (swap)      data_q <= shadow_in;
    else if (shift_evt) data_q <= shifted;
  end

  // R1 single-lane shift moves every bit down by one
  AST_SER1_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !swap && lane_mode == LANE_X1)
      |=> (data_q[DATA_W-2:0] == $past(data_q[DATA_W-1:1]))); // R1

  // R6 with no event the working register holds
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(data_q)); // R6

endmodule

// File: rtl/serial_shift_slice.sv
module serial_shift_slice
  import shift_slice_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 12,
  parameter int POS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_lane_mode,
  input  logic                cfg_ext_sel,
  input  logic                cfg_qual_en,
  input  logic                ext_clk_in,
  input  logic                qual_in,
  input  logic [LANE_MAX-1:0] ser_in,
  output logic [LANE_MAX-1:0] ser_out,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [2:0]          rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                swap_pulse
);

  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int POS_PAD = DATA_W - POS_W;

  logic              shift_evt;
  logic              swap;
  logic [CNT_W-1:0]  div_reload;
  logic [CNT_W-1:0]  div_count;
  logic [POS_W-1:0]  word_reload;
  logic [POS_W-1:0]  word_count;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] shifted;
  logic              shadow_wr;

  tick_source #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_sel    (cfg_ext_sel),
    .qual_en    (cfg_qual_en),
    .ext_clk_in (ext_clk_in),
    .qual_in    (qual_in),
    .reload_wr  (wr_en && wr_addr == ADDR_DIV_RELOAD),
    .count_wr   (wr_en && wr_addr == ADDR_DIV_COUNT),
    .wr_val     (wr_data[CNT_W-1:0]),
    .reload_q   (div_reload),
    .count_q    (div_count),
    .shift_evt  (shift_evt)
  );

  word_counter #(
    .POS_W (POS_W)
  ) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_evt (shift_evt),
    .reload_wr (wr_en && wr_addr == ADDR_WORD_RELOAD),
    .count_wr  (wr_en && wr_addr == ADDR_WORD_COUNT),
    .wr_val    (wr_data[POS_W-1:0]),
    .reload_q  (word_reload),
    .count_q   (word_count),
    .boundary  (swap)
  );

  lane_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_mode (lane_mode_e'(cfg_lane_mode)),
    .shift_evt (shift_evt),
    .swap      (swap),
    .ser_in    (ser_in),
    .shadow_in (shadow_q),
    .shifted   (shifted),
    .ser_out   (ser_out)
  );

  // shadow word: exchange wins over a host write in the same cycle
  assign shadow_wr = wr_en && (wr_addr == ADDR_SHADOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (swap)      shadow_q <= shifted;
    else if (shadow_wr) shadow_q <= wr_data;
  end

  assign swap_pulse = swap;

  always_comb begin
    case (rd_addr)
      ADDR_DIV_RELOAD:  rd_data = {{CNT_PAD{1'b0}}, div_reload};
      ADDR_DIV_COUNT:   rd_data = {{CNT_PAD{1'b0}}, div_count};
      ADDR_WORD_RELOAD: rd_data = {{POS_PAD{1'b0}}, word_reload};
      ADDR_WORD_COUNT:  rd_data = {{POS_PAD{1'b0}}, word_count};
      ADDR_SHADOW:      rd_data = shadow_q;
      default:          rd_data = '0;
    endcase
  end

  // R6 an exchange only happens on a shift event
  AST_SWAP_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> shift_evt); // R6

  // R6 shadow changes only by exchange or host write
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_pulse && !shadow_wr) |=> $stable(shadow_q)); // R6

  // R2 lanes above the selected width read zero
  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lane_mode == LANE_X1) |-> (ser_out[LANE_MAX-1:1] == '0)); // R2

endmodule

// File: tb/serial_shift_slice_test.sv
module serial_shift_slice_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] seed;
    logic [7:0]  d1;
    logic [7:0]  d2;
    logic [7:0]  out1;
    logic [31:0] word;
  } vec_t;

  // seed word, two lane inputs (junk above N), output after first shift, word after second
  localparam vec_t VECS [5] = '{
    '{2'd0, 32'h8000_0003, 8'hFF, 8'hFE, 8'h01, 32'h6000_0000},
    '{2'd1, 32'h0000_00F7, 8'hF6, 8'h0D, 8'h01, 32'h6000_000F},
    '{2'd2, 32'h1234_5678, 8'h3A, 8'hC5, 8'h07, 32'h5A12_3456},
    '{2'd3, 32'hDEAD_BEEF, 8'h3C, 8'hC3, 8'hBE, 32'hC33C_DEAD},
    '{2'd3, 32'h0000_0000, 8'hFF, 8'h00, 8'h00, 32'h00FF_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_lane_mode = 2'd0;
  logic        cfg_ext_sel = 1'b0;
  logic        cfg_qual_en = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic        qual_in = 1'b0;
  logic [7:0]  ser_in = 8'h00;
  logic [7:0]  ser_out;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [31:0] wr_data = 32'h0;
  logic [2:0]  rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic        swap_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  serial_shift_slice uut (
    .clk (clk), .rst_n (rst_n),
    .cfg_lane_mode (cfg_lane_mode), .cfg_ext_sel (cfg_ext_sel),
    .cfg_qual_en (cfg_qual_en), .ext_clk_in (ext_clk_in), .qual_in (qual_in),
    .ser_in (ser_in), .ser_out (ser_out),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .swap_pulse (swap_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic host_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_read(logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // rising edge on the pin, event visible two edges later, then settle low
  task automatic ext_pulse(output logic saw);
    @(negedge clk); ext_clk_in = 1'b1;
    @(negedge clk);
    @(negedge clk); saw = swap_pulse;
    @(negedge clk); ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_swaps(int n, output int cnt, output int first, output int second);
    cnt = 0; first = -1; second = -1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (swap_pulse) begin
        cnt++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic        sw;
    int          cnt, first, second;

    // reset state, R9
    repeat (3) @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      host_read(3'(a), rv);
      check("R9", "reset register value", rv, 32'h0);
    end
    check("R9", "reset swap_pulse", {31'h0, swap_pulse}, 32'h0);
    check("R2", "reset ser_out", {24'h0, ser_out}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // readback in external mode with the pin idle, R9
    cfg_ext_sel = 1'b1;
    host_write(3'd0, 32'hFFFF_F123);
    host_read(3'd0, rv);  check("R9", "divider reload masked", rv, 32'h0000_0123);
    host_write(3'd2, 32'h0000_07A5);
    host_read(3'd2, rv);  check("R9", "word reload masked", rv, 32'h0000_00A5);
    host_write(3'd3, 32'h0000_0042);
    host_read(3'd3, rv);  check("R9", "word count readback", rv, 32'h0000_0042);
    host_write(3'd1, 32'h0000_0100);
    host_read(3'd1, rv);  check("R4", "divider count written", rv, 32'h0000_0100);

    // external mode ignores the local counter, R7
    host_write(3'd0, 32'h0);
    host_write(3'd1, 32'h0);
    host_write(3'd2, 32'h0);
    host_write(3'd3, 32'h0);
    count_swaps(20, cnt, first, second);
    check("R7", "no events from idle external pin", cnt, 0);

    // vector table: external single-step shifts in every lane width, R1 R2 R5 R6 R7
    foreach (VECS[i]) begin
      host_write(3'd2, 32'd1);
      host_write(3'd4, VECS[i].seed);
      host_write(3'd3, 32'd0);
      cfg_lane_mode = VECS[i].mode;
      ser_in = 8'h00;
      ext_pulse(sw);
      check("R6", "load exchange strobe", {31'h0, sw}, 32'h1);
      ser_in = VECS[i].d1;
      ext_pulse(sw);
      check("R5", "mid-word no exchange", {31'h0, sw}, 32'h0);
      check("R2", "ser_out after first shift", {24'h0, ser_out}, {24'h0, VECS[i].out1});
      ser_in = VECS[i].d2;
      ext_pulse(sw);
      check("R7", "external edge gives exchange", {31'h0, sw}, 32'h1);
      host_read(3'd4, rv);
      check("R1", "shifted word in shadow", rv, VECS[i].word);
    end
    cfg_lane_mode = 2'd0;

    // local divider rate and phase, R3 R4 R5 (word reload 0: every event swaps)
    cfg_ext_sel = 1'b0;
    host_write(3'd0, 32'd4);
    host_write(3'd2, 32'd0);
    host_write(3'd3, 32'd0);
    host_write(3'd1, 32'd4);
    count_swaps(50, cnt, first, second);
    check("R4", "first event after count write of 4", first, 4);
    check("R3", "event spacing reload+1", second - first, 5);
    check("R3", "events in 50 cycles", cnt, 10);
    check("R5", "reload 0 swaps every event", cnt, 10);
    host_write(3'd1, 32'd2);
    count_swaps(10, cnt, first, second);
    check("R4", "first event after count write of 2", first, 2);

    // word length of three events, R5
    host_write(3'd0, 32'd0);
    host_write(3'd1, 32'd0);
    host_write(3'd2, 32'd2);
    host_write(3'd3, 32'd2);
    count_swaps(30, cnt, first, second);
    check("R5", "first boundary after word count 2", first, 2);
    check("R5", "boundary spacing reload+1", second - first, 3);
    check("R5", "boundaries in 30 events", cnt, 10);

    // qualifier, R8
    host_write(3'd2, 32'd0);
    host_write(3'd3, 32'd0);
    cfg_qual_en = 1'b1; qual_in = 1'b0;
    host_write(3'd4, 32'h5555_AAAA);
    count_swaps(20, cnt, first, second);
    check("R8", "low qualifier blocks exchanges", cnt, 0);
    host_read(3'd4, rv);
    check("R8", "shadow untouched while blocked", rv, 32'h5555_AAAA);
    qual_in = 1'b1;
    count_swaps(20, cnt, first, second);
    check("R8", "high qualifier passes events", cnt, 20);
    cfg_qual_en = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule